// File: doc/BRIEF.md
# LPC Firmware Memory Target Cycle Engine

This block is the bus-facing front end of a byte-wide firmware memory that sits on the Low Pin Count bus and runs on the 33 MHz bus clock. It watches the frame strobe and the four multiplexed address/data lines. It recognises a qualified start, decodes a memory read or memory write cycle and collects a 32-bit address nibble by nibble. It then issues one single-byte request to a simple internal memory/register port and answers the host with wait and ready SYNC codes, read data and the closing turnaround.

The host side is split into separate input, output and output-enable pins, so the pad ring can build the shared bus. A chip enable must be low one clock before the frame strobe falls, or the target ignores the cycle. Pulling the frame strobe low at any point ends the cycle in progress. Either of two active-low reset inputs returns the engine to idle. The same low level removes the target's drive from the bus in the same cycle, even in the middle of a read.

Top module: `lpc_fw_target`

## Requirements
- R1: A cycle begins only if the frame strobe has been low for at least two consecutive clocks and the lines carry 4'b0000 on the last low clock. A frame strobe that is low for a single clock starts nothing.
- R2: If chip enable was not low on the clock before the frame strobe fell, the cycle is ignored: no request is made and the lines are not driven.
- R3: The nibble on the first clock after the frame strobe rises selects the cycle: 4'b0100 is a memory read and 4'b0110 is a memory write. Any other value is ignored until the next frame.
- R4: Eight address nibbles follow, most significant first, and form `mem_addr`. For a write, two data nibbles then follow, low nibble first, and form `mem_wdata`. The address stays stable while the request is pending.
- R5: After the host's two-clock turnaround, `mem_req` rises and stays high until `mem_ack` is sampled. Each completed cycle makes exactly one request.
- R6: From the first SYNC clock the target drives long-wait 4'b0110 on every clock up to and including the clock in which `mem_ack` is sampled. It then drives one ready code, 4'b0000, on the next clock. With an acknowledge after N waiting clocks, the host sees N+1 long-wait codes.
- R7: On a read, the clocks after ready carry the byte low nibble first, then high nibble. The target then drives 4'b1111 for one clock and releases the lines.
- R8: On a write, the clock after ready carries 4'b1111 from the target, after which the lines are released.
- R9: The target never drives the lines during the start, cycle type, address, write data or host turnaround clocks.
- R10: A low frame strobe during any phase aborts the cycle. From the next clock the request is dropped and the lines are released, and a new qualified start is accepted.
- R11: A low level on `rst_n` or `init_n` forces `lad_oe` low in the same cycle. At the next clock edge the engine returns to idle with no request pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bus clock (33 MHz) |
| rst_n | input | 1 | active-low synchronous reset, first source |
| init_n | input | 1 | active-low synchronous reset, second source |
| ce_n | input | 1 | active-low chip enable |
| lframe_n | input | 1 | active-low frame strobe from the host |
| lad_in | input | 4 | nibble seen on the shared lines |
| lad_out | output | 4 | nibble the target drives |
| lad_oe | output | 1 | target output enable for the shared lines |
| mem_req | output | 1 | internal port request, held until acknowledged |
| mem_we | output | 1 | 1 for a write request |
| mem_addr | output | AW (32) | request address |
| mem_wdata | output | DW (8) | write byte |
| mem_ack | input | 1 | one-clock acknowledge from the internal port |
| mem_rdata | input | DW (8) | read byte, valid with `mem_ack` |

## Verification
The checker watches several rules on every clock:
- the request is held until acknowledged and its address does not move;
- every pending-request clock shows the long-wait code;
- the clock after an acknowledge shows the ready code;
- a low frame strobe clears both request and drive on the next clock;
- a low reset input never leaves the lines driven.

Other behaviour depends on a host sequence and is only shown by the bench's scenarios:
- start qualification by strobe length and by chip-enable setup;
- cycle-type filtering;
- nibble order of address and data;
- the exact wait count;
- the closing turnaround;
- recovery after an abort or a reset mid-read.

// File: rtl/lpc_tgt_pkg.sv
// Package: shared phase type and bus nibble codes for the LPC target engine.
// Assumes: single-byte memory cycles only; codes match the LPC signalling.
package lpc_tgt_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,   // waiting for a qualified start and a cycle type
        PH_ADDR,   // collecting address nibbles
        PH_WDAT,   // collecting write data nibbles
        PH_HTAR,   // host-owned turnaround
        PH_SYNC,   // target drives wait / ready codes
        PH_RDAT,   // target drives read data nibbles
        PH_TTAR    // target-owned turnaround
    } phase_t;

    localparam logic [3:0] NIB_START  = 4'b0000;
    localparam logic [3:0] NIB_MEM_RD = 4'b0100;
    localparam logic [3:0] NIB_MEM_WR = 4'b0110;
    localparam logic [3:0] NIB_READY  = 4'b0000;
    localparam logic [3:0] NIB_LWAIT  = 4'b0110;
    localparam logic [3:0] NIB_PARK   = 4'b1111;

endpackage

// File: rtl/lpc_frame_detect.sv
// Module: qualifies a frame start.
// A start is armed on a clock where the frame strobe has been low for at
// least MIN_LOW clocks, the lines carry the start code, and chip enable was
// low on the clock before the strobe fell. The armed flag is consumed by the
// cycle FSM on the first clock with the strobe high.
// Assumes: rst_all_n is the synchronous OR of the two reset sources.
module lpc_frame_detect
    import lpc_tgt_pkg::*;
#(
    parameter int MIN_LOW = 2
) (
    input  logic       clk,
    input  logic       rst_all_n,
    input  logic       ce_n,
    input  logic       lframe_n,
    input  logic [3:0] lad_in,
    output logic       armed
);
    localparam int CW = $clog2(MIN_LOW + 1);

    logic [CW-1:0] low_cnt;
    logic          ce_prev_n;
    logic          ce_ok_q;
    logic          armed_q;
    logic          ce_ok_now;

    // Chip-enable setup is judged on the first low clock, then remembered.
    assign ce_ok_now = (low_cnt == '0) ? !ce_prev_n : ce_ok_q;

    // Count strobe-low clocks, track chip-enable setup and arm the start.
    always_ff @(posedge clk) begin
        if (!rst_all_n) begin
            low_cnt   <= '0;
            ce_prev_n <= 1'b1;
            ce_ok_q   <= 1'b0;
            armed_q   <= 1'b0;
        end else begin
            ce_prev_n <= ce_n;
            if (lframe_n) begin
                low_cnt <= '0;
                armed_q <= 1'b0;
            end else begin
                if (low_cnt != CW'(MIN_LOW))
                    low_cnt <= low_cnt + 1'b1;
                if (low_cnt == '0)
                    ce_ok_q <= !ce_prev_n;
                armed_q <= (low_cnt >= CW'(MIN_LOW - 1)) &&
                           (lad_in == NIB_START) && ce_ok_now;
            end
        end
    end

    assign armed = armed_q;

endmodule

// File: rtl/lpc_cycle_fsm.sv
// Module: cycle sequencer.
// It decodes the cycle type, shifts in the address and the write data,
// raises the internal request after the host turnaround, and steps through
// SYNC, read data and the target turnaround. A low frame strobe in any
// phase returns it to idle.
// Assumes: ADDR_NIB >= DATA_NIB >= 2; mem_ack is a one-clock pulse.
module lpc_cycle_fsm
    import lpc_tgt_pkg::*;
#(
    parameter int ADDR_NIB = 8,
    parameter int DATA_NIB = 2,
    parameter int CNTW     = 3
) (
    input  logic                  clk,
    input  logic                  rst_all_n,
    input  logic                  lframe_n,
    input  logic [3:0]            lad_in,
    input  logic                  armed,
    input  logic                  mem_ack,
    input  logic [4*DATA_NIB-1:0] mem_rdata,
    output phase_t                phase,
    output logic [CNTW-1:0]       cnt,
    output logic                  done,
    output logic [4*DATA_NIB-1:0] rdata,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [4*ADDR_NIB-1:0] mem_addr,
    output logic [4*DATA_NIB-1:0] mem_wdata
);
    localparam int AW = 4 * ADDR_NIB;

    phase_t                phase_q;
    logic [CNTW-1:0]       cnt_q;
    logic                  wr_q;
    logic                  done_q;
    logic [AW-1:0]         addr_q;
    logic [4*DATA_NIB-1:0] wdata_q;
    logic [4*DATA_NIB-1:0] rdata_q;

    // Advance the cycle one bus clock at a time; abort wins over every phase.
    always_ff @(posedge clk) begin
        if (!rst_all_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            wr_q    <= 1'b0;
            done_q  <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else if (!lframe_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (armed && (lad_in == NIB_MEM_RD || lad_in == NIB_MEM_WR)) begin
                        phase_q <= PH_ADDR;
                        wr_q    <= (lad_in == NIB_MEM_WR);
                        cnt_q   <= '0;
                    end
                end
                PH_ADDR: begin
                    addr_q <= {addr_q[AW-5:0], lad_in};
                    if (cnt_q == CNTW'(ADDR_NIB - 1)) begin
                        cnt_q   <= '0;
                        phase_q <= wr_q ? PH_WDAT : PH_HTAR;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_WDAT: begin
                    wdata_q[int'(cnt_q)*4 +: 4] <= lad_in;
                    if (cnt_q == CNTW'(DATA_NIB - 1)) begin
                        cnt_q   <= '0;
                        phase_q <= PH_HTAR;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_HTAR: begin
                    if (cnt_q == CNTW'(1)) begin
                        cnt_q   <= '0;
                        done_q  <= 1'b0;
                        phase_q <= PH_SYNC;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_SYNC: begin
                    if (!done_q && mem_ack) begin
                        done_q  <= 1'b1;
                        rdata_q <= mem_rdata;
                    end
                    if (done_q) begin
                        cnt_q   <= '0;
                        phase_q <= wr_q ? PH_TTAR : PH_RDAT;
                    end
                end
                PH_RDAT: begin
                    if (cnt_q == CNTW'(DATA_NIB - 1)) begin
                        cnt_q   <= '0;
                        phase_q <= PH_TTAR;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_TTAR: begin
                    if (cnt_q == CNTW'(1)) begin
                        cnt_q   <= '0;
                        phase_q <= PH_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase     = phase_q;
    assign cnt       = cnt_q;
    assign done      = done_q;
    assign rdata     = rdata_q;
    assign mem_req   = (phase_q == PH_SYNC) && !done_q;
    assign mem_we    = wr_q;
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;

endmodule

// File: rtl/lpc_lad_driver.sv
// Module: builds the target's nibble and output enable from the cycle state.
// The enable is gated directly by both reset inputs, so a reset releases the
// lines in the same cycle it is applied.
// Assumes: phase/cnt/done come from registers, so outputs are glitch-free.
module lpc_lad_driver
    import lpc_tgt_pkg::*;
#(
    parameter int DATA_NIB = 2,
    parameter int CNTW     = 3
) (
    input  phase_t                phase,
    input  logic [CNTW-1:0]       cnt,
    input  logic                  done,
    input  logic [4*DATA_NIB-1:0] rdata,
    input  logic                  rst_n,
    input  logic                  init_n,
    output logic [3:0]            lad_out,
    output logic                  lad_oe
);
    logic       drive;
    logic [3:0] nib;

    // Select the nibble owed to the host in the current phase.
    always_comb begin
        drive = 1'b0;
        nib   = 4'b0000;
        unique case (phase)
            PH_SYNC: begin
                drive = 1'b1;
                nib   = done ? NIB_READY : NIB_LWAIT;
            end
            PH_RDAT: begin
                drive = 1'b1;
                nib   = rdata[int'(cnt)*4 +: 4];
            end
            PH_TTAR: begin
                drive = (cnt == '0);
                nib   = (cnt == '0) ? NIB_PARK : 4'b0000;
            end
            default: begin
                drive = 1'b0;
                nib   = 4'b0000;
            end
        endcase
    end

    assign lad_oe  = drive && rst_n && init_n;
    assign lad_out = lad_oe ? nib : 4'b0000;

endmodule

// File: rtl/lpc_fw_target.sv
// Module: top of the LPC firmware memory target cycle engine.
// It joins start qualification, the cycle sequencer and the line driver. The
// shared bus is presented as separate in/out/enable pins for the pad ring.
// Assumes: the clock is the bus clock; both reset inputs are synchronous to it.
module lpc_fw_target
    import lpc_tgt_pkg::*;
#(
    parameter int ADDR_NIB = 8,
    parameter int DATA_NIB = 2,
    parameter int MIN_LOW  = 2,
    localparam int AW      = 4 * ADDR_NIB,
    localparam int DW      = 4 * DATA_NIB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_n,
    input  logic          ce_n,
    input  logic          lframe_n,
    input  logic [3:0]    lad_in,
    output logic [3:0]    lad_out,
    output logic          lad_oe,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata
);
    localparam int CNT_MAX = (ADDR_NIB > DATA_NIB) ? ADDR_NIB : DATA_NIB;
    localparam int CNTW    = (CNT_MAX > 2) ? $clog2(CNT_MAX) : 1;

    logic            rst_all_n;
    logic            armed;
    phase_t          phase;
    logic [CNTW-1:0] cnt;
    logic            done;
    logic [DW-1:0]   rdata;

    assign rst_all_n = rst_n && init_n;

    lpc_frame_detect #(.MIN_LOW(MIN_LOW)) u_detect (
        .clk       (clk),
        .rst_all_n (rst_all_n),
        .ce_n      (ce_n),
        .lframe_n  (lframe_n),
        .lad_in    (lad_in),
        .armed     (armed)
    );

    lpc_cycle_fsm #(.ADDR_NIB(ADDR_NIB), .DATA_NIB(DATA_NIB), .CNTW(CNTW)) u_fsm (
        .clk       (clk),
        .rst_all_n (rst_all_n),
        .lframe_n  (lframe_n),
        .lad_in    (lad_in),
        .armed     (armed),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .phase     (phase),
        .cnt       (cnt),
        .done      (done),
        .rdata     (rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    lpc_lad_driver #(.DATA_NIB(DATA_NIB), .CNTW(CNTW)) u_drv (
        .phase   (phase),
        .cnt     (cnt),
        .done    (done),
        .rdata   (rdata),
        .rst_n   (rst_n),
        .init_n  (init_n),
        .lad_out (lad_out),
        .lad_oe  (lad_oe)
    );

endmodule

// File: rtl/lpc_fw_target_chk.sv
// Module: protocol checker bound to the target top; observes ports only.
module lpc_fw_target_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          init_n,
    input logic          lframe_n,
    input logic [3:0]    lad_out,
    input logic          lad_oe,
    input logic          mem_req,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr
);
    // Reset inputs must never coexist with a driven bus.
    always @(posedge clk) begin
        if (!rst_n || !init_n)
            AST_RESET_FLOATS: assert (!lad_oe); // R11
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n || !init_n)
        (mem_req && !mem_ack && lframe_n) |=> mem_req); // R5

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n || !init_n)
        (mem_req && $past(mem_req)) |-> $stable(mem_addr)); // R4

    AST_WAIT_CODE: assert property (@(posedge clk) disable iff (!rst_n || !init_n)
        mem_req |-> (lad_oe && lad_out == 4'b0110)); // R6

    AST_READY_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n || !init_n)
        (mem_req && mem_ack && lframe_n) |=> (lad_oe && lad_out == 4'b0000)); // R6

    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n || !init_n)
        !lframe_n |=> (!mem_req && !lad_oe)); // R10

endmodule

bind lpc_fw_target lpc_fw_target_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_n   (init_n),
    .lframe_n (lframe_n),
    .lad_out  (lad_out),
    .lad_oe   (lad_oe),
    .mem_req  (mem_req),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr)
);

// File: tb/lpc_fw_target_test.sv
// Directed bench: host model on the bus side, memory model on the port side.
module lpc_fw_target_test;
    localparam time CLK_PERIOD = 30ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0, init_n = 1'b1, ce_n = 1'b0, lframe_n = 1'b1;
    logic [3:0]  lad_in = 4'hF;
    logic [3:0]  lad_out;
    logic        lad_oe, mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata = 8'h00;

    int total = 0, bad = 0;
    int mem_delay = 0, wait_cnt = 0, req_count = 0;
    logic [7:0]  mem [256];
    logic [31:0] last_addr;
    logic        last_we;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpc_fw_target uut (
        .clk(clk), .rst_n(rst_n), .init_n(init_n), .ce_n(ce_n),
        .lframe_n(lframe_n), .lad_in(lad_in), .lad_out(lad_out), .lad_oe(lad_oe),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // Memory port model: acknowledges after mem_delay waiting clocks.
    always @(negedge clk) begin
        if (mem_req && !mem_ack) begin
            if (wait_cnt >= mem_delay) begin
                mem_ack   = 1'b1;
                mem_rdata = mem[mem_addr[7:0]];
                if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
                last_addr = mem_addr;
                last_we   = mem_we;
                req_count++;
                wait_cnt  = 0;
            end else begin
                wait_cnt++;
            end
        end else begin
            mem_ack  = 1'b0;
            wait_cnt = 0;
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // One host-driven bus clock; the target must not drive (R9) when asked.
    task automatic host_clk(input logic fr, input logic [3:0] nib, input bit quiet);
        @(negedge clk);
        if (quiet && lad_oe) chk(1'b0, "R9 target drove in host phase", lad_oe, 0);
        lframe_n = fr;
        lad_in   = nib;
    endtask

    task automatic host_header(input bit wr, input logic [31:0] a, input logic [7:0] wd,
                               input logic [3:0] typ);
        host_clk(1'b0, 4'h0, 1'b1);
        host_clk(1'b0, 4'h0, 1'b1);
        host_clk(1'b1, typ, 1'b1);
        for (int i = 0; i < 8; i++) host_clk(1'b1, a[31-4*i -: 4], 1'b1);
        if (wr) begin
            host_clk(1'b1, wd[3:0], 1'b1);
            host_clk(1'b1, wd[7:4], 1'b1);
        end
        host_clk(1'b1, 4'hF, 1'b1);
        host_clk(1'b1, 4'hF, 1'b1);
    endtask

    // Full cycle with SYNC, data and turnaround checks.
    task automatic lpc_xfer(input bit wr, input logic [31:0] a, input logic [7:0] wd,
                            input int delay, output logic [7:0] rd);
        int  waits = 0;
        bit  ready = 0;
        int  base;
        mem_delay = delay;
        base = req_count;
        rd = 8'h00;
        host_header(wr, a, wd, wr ? 4'b0110 : 4'b0100);
        for (int k = 0; k < 200 && !ready; k++) begin
            @(negedge clk);
            if (lad_oe && lad_out == 4'b0110) waits++;
            else if (lad_oe && lad_out == 4'b0000) ready = 1;
            else break;
        end
        chk(ready, "R6 ready code", ready, 1);
        chk(waits == delay + 1, "R6 long-wait count", waits, delay + 1);
        if (!wr) begin
            @(negedge clk);
            chk(lad_oe, "R7 low nibble driven", lad_oe, 1);
            rd[3:0] = lad_out;
            @(negedge clk);
            rd[7:4] = lad_out;
        end
        @(negedge clk);
        chk(lad_oe && lad_out == 4'hF, wr ? "R8 park nibble" : "R7 park nibble", {lad_oe, lad_out}, 5'h1F);
        @(negedge clk);
        chk(!lad_oe, wr ? "R8 release" : "R7 release", lad_oe, 0);
        chk(req_count == base + 1, "R5 one request", req_count - base, 1);
        chk(last_addr == a, "R4 address", last_addr, a);
        chk(last_we == wr, "R3 direction", last_we, wr);
    endtask

    task automatic watch_quiet(input int n, input string rq);
        bit ok = 1;
        int base = req_count;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (lad_oe || mem_req) ok = 0;
        end
        chk(ok && req_count == base, rq, {lad_oe, mem_req}, 0);
    endtask

    task automatic t_reset;
        chk(!lad_oe && !mem_req, "R11 reset state", {lad_oe, mem_req}, 0);
    endtask

    task automatic t_basic;
        logic [7:0] rd;
        lpc_xfer(1'b1, 32'hFFC0_0012, 8'hA5, 0, rd);
        chk(mem[8'h12] == 8'hA5, "R4 write data nibble order", mem[8'h12], 8'hA5);
        lpc_xfer(1'b0, 32'hFFC0_0012, 8'h00, 0, rd);
        chk(rd == 8'hA5, "R7 read data", rd, 8'hA5);
    endtask

    task automatic t_back_to_back;
        logic [7:0] rd;
        lpc_xfer(1'b1, 32'hFFC0_0033, 8'h3C, 3, rd);
        lpc_xfer(1'b1, 32'hFF80_0034, 8'hE1, 1, rd);
        lpc_xfer(1'b0, 32'h000E_0033, 8'h00, 5, rd);
        chk(rd == 8'h3C, "R7 read after delay", rd, 8'h3C);
        lpc_xfer(1'b0, 32'hFFFF_FF34, 8'h00, 2, rd);
        chk(rd == 8'hE1, "R7 read second byte", rd, 8'hE1);
    endtask

    task automatic t_short_frame;
        host_clk(1'b0, 4'h0, 1'b1);
        host_clk(1'b1, 4'b0100, 1'b1);
        for (int i = 0; i < 12; i++) host_clk(1'b1, 4'h1, 1'b1);
        watch_quiet(10, "R1 single-clock frame ignored");
    endtask

    task automatic t_ce_late;
        logic [7:0] rd;
        @(negedge clk); ce_n = 1'b1;
        @(negedge clk); ce_n = 1'b0; lframe_n = 1'b0; lad_in = 4'h0;
        host_clk(1'b0, 4'h0, 1'b1);
        host_clk(1'b1, 4'b0100, 1'b1);
        for (int i = 0; i < 10; i++) host_clk(1'b1, 4'h2, 1'b1);
        watch_quiet(10, "R2 late chip enable ignored");
        lpc_xfer(1'b0, 32'hFFC0_0012, 8'h00, 0, rd);
        chk(rd == 8'hA5, "R2 normal cycle after setup", rd, 8'hA5);
    endtask

    task automatic t_bad_type;
        host_header(1'b0, 32'hFFC0_0012, 8'h00, 4'b0000);
        watch_quiet(10, "R3 foreign cycle type ignored");
    endtask

    task automatic t_abort;
        logic [7:0] rd;
        int base;
        // Abort during address, then a new cycle runs.
        host_clk(1'b0, 4'h0, 1'b1);
        host_clk(1'b0, 4'h0, 1'b1);
        host_clk(1'b1, 4'b0110, 1'b1);
        for (int i = 0; i < 4; i++) host_clk(1'b1, 4'hF, 1'b1);
        host_clk(1'b0, 4'hF, 1'b1);
        host_clk(1'b0, 4'hF, 1'b1);
        lpc_xfer(1'b1, 32'hFFC0_0040, 8'h96, 0, rd);
        chk(mem[8'h40] == 8'h96, "R10 cycle after address abort", mem[8'h40], 8'h96);
        // Abort while the target waits in SYNC.
        base = req_count;
        mem_delay = 40;
        host_header(1'b0, 32'hFFC0_0040, 8'h00, 4'b0100);
        for (int i = 0; i < 3; i++) @(negedge clk);
        lframe_n = 1'b0; lad_in = 4'hF;
        @(negedge clk);
        chk(!lad_oe && !mem_req, "R10 abort in SYNC releases", {lad_oe, mem_req}, 0);
        chk(req_count == base, "R10 no completion", req_count - base, 0);
        lframe_n = 1'b1;
        lpc_xfer(1'b0, 32'hFFC0_0040, 8'h00, 0, rd);
        chk(rd == 8'h96, "R10 read after SYNC abort", rd, 8'h96);
    endtask

    task automatic t_reset_mid_read;
        logic [7:0] rd;
        mem_delay = 40;
        host_header(1'b0, 32'hFFC0_0012, 8'h00, 4'b0100);
        @(negedge clk);
        chk(lad_oe, "R11 driving before reset", lad_oe, 1);
        @(negedge clk);
        init_n = 1'b0;
        #1;
        chk(!lad_oe, "R11 immediate release", lad_oe, 0);
        @(negedge clk);
        init_n = 1'b1;
        chk(!mem_req && !lad_oe, "R11 idle after reset edge", {lad_oe, mem_req}, 0);
        lpc_xfer(1'b0, 32'hFFC0_0012, 8'h00, 1, rd);
        chk(rd == 8'hA5, "R11 read after reset", rd, 8'hA5);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_basic();
        t_back_to_back();
        t_short_frame();
        t_ce_late();
        t_bad_type();
        t_abort();
        t_reset_mid_read();
        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule